// File: doc/BRIEF.md
# ADC conversion timing sequencer

This block paces a single analog-to-digital conversion that passes through a programmable-gain amplifier front end. A start pulse in the ADC clock domain launches a fixed series of phases. First comes an optional power-up and settling phase. The amplifier settles first and then begins tracking the input while the converter is still settling. The amplifier then samples for a programmed time, the converter samples for its own programmed time, and the conversion runs for a length set by the resolution. A one-cycle hand-off stage follows. The phase outputs drive the analog macros. The converted word comes from an external analog model and is captured on the falling ADC clock edge after the conversion. It is then moved into the main clock domain and presented with a one-cycle valid strobe.

A low-latency setting keeps the analog sections powered between conversions. The following trigger then skips settling, and the amplifier keeps tracking its input while idle. A free-running setting starts the next conversion straight out of the hand-off stage, so no trigger is needed. Clearing that setting lets the conversion in flight complete and then parks the block. The resolution and both sample durations are latched at the start of each conversion.

Top module: `adc_conv_sequencer`

## Requirements
- R1: The conversion phase (`conv_o` high) lasts 9 ADC cycles when `res8_i` was 1 at the start of the conversion, and 13 ADC cycles otherwise.
- R2: The converter sampling phase (`adc_samp_o` high) lasts `samp_dur_i`+1 ADC cycles, using the value latched at the start of the conversion.
- R3: From the unpowered state, `adc_init_o` is high for INIT_CYC cycles. `pga_init_o` is high for the first PGA_INIT_CYC of those cycles. `pga_samp_o` then rises inside the settling window, so its first run lasts (INIT_CYC−PGA_INIT_CYC)+`pga_dur_i`+1 cycles.
- R4: When the previous conversion ended with `lowlat_i`=1, the next conversion never raises `adc_init_o` or `pga_init_o`.
- R5: In idle after a conversion that ended with `lowlat_i`=1, `adc_pwr_o` and `pga_samp_o` stay high. After a conversion that ended with `lowlat_i`=0, and after reset, both are low.
- R6: In 12-bit mode `result_o` equals `conv_data_i`. In 8-bit mode it is {4'b0, `conv_data_i`[7:0]}, and bits 11:8 of the data input are ignored.
- R7: Each conversion produces exactly one `result_valid_o` pulse, one main-clock cycle wide. It rises no more than 4 ADC cycles after `conv_o` falls.
- R8: With free-running and low-latency both set, successive falls of `conv_o` are `pga_dur_i`+`samp_dur_i`+conversion length+3 ADC cycles apart.
- R9: Clearing `freerun_i` during a free-running conversion lets that conversion finish and deliver its result, and then no further conversion starts.
- R10: A start pulse that arrives while a conversion is in progress is ignored. No extra result appears, and the phase lengths are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_adc | input | 1 | ADC clock; phases counted in its cycles |
| clk_main | input | 1 | Main clock for the result interface |
| rst_n | input | 1 | Synchronous active-low reset, seen by both domains |
| start_i | input | 1 | Conversion trigger, ADC domain |
| res8_i | input | 1 | 1 selects 8-bit resolution |
| pga_dur_i | input | DUR_W | Amplifier sample duration minus one |
| samp_dur_i | input | DUR_W | Converter sample duration minus one |
| lowlat_i | input | 1 | Keep analog sections powered between conversions |
| freerun_i | input | 1 | Restart automatically after each result |
| conv_data_i | input | RES_W | Converted word from the analog model |
| adc_pwr_o | output | 1 | Analog sections powered |
| adc_init_o | output | 1 | Converter settling phase |
| pga_init_o | output | 1 | Amplifier settling phase |
| pga_samp_o | output | 1 | Amplifier tracking its input |
| adc_samp_o | output | 1 | Converter sampling phase |
| conv_o | output | 1 | Conversion phase |
| result_valid_o | output | 1 | One main-cycle strobe with a new result |
| result_o | output | RES_W | Result word, main domain |

## Verification
The hardest case to reach is a free-running sequence that is stopped mid-flight. By the time the bench sees a result, the next conversion has already begun, so clearing the enable must still yield exactly one more result and then silence. The bench enables free-running with low latency, counts three results, clears the enable, and then watches a long quiet window. Skipped settling depends on what the previous conversion left behind. Random runs therefore alternate the low-latency setting, and the bench tracks the expected power state from one run to the next.

// File: rtl/adc_seq_pkg.sv
// Shared types for the conversion sequencer.
// Assumes: one phase is active at a time in the ADC clock domain.
package adc_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_PGA,
        ST_ASAMP,
        ST_CONV,
        ST_POST
    } seq_state_t;
endpackage

// File: rtl/adc_seq_fsm.sv
// Phase sequencer in the ADC clock domain. It steps through settling,
// amplifier sampling, converter sampling, conversion and hand-off, and
// uses one shared counter for every phase.
// Assumes: start_i is synchronous to clk_adc. Durations are latched at start.
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int INIT_CYC     = 8,
    parameter int PGA_INIT_CYC = 3,
    parameter int DUR_W        = 4,
    parameter int CONV_LONG    = 13,
    parameter int CONV_SHORT   = 9
) (
    input  logic             clk_adc,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             res8_i,
    input  logic [DUR_W-1:0] pga_dur_i,
    input  logic [DUR_W-1:0] samp_dur_i,
    input  logic             lowlat_i,
    input  logic             freerun_i,
    output logic             adc_pwr_o,
    output logic             adc_init_o,
    output logic             pga_init_o,
    output logic             pga_samp_o,
    output logic             adc_samp_o,
    output logic             conv_o,
    output logic             post_o,
    output logic             res8_o
);
    localparam int MAX_A   = (INIT_CYC > CONV_LONG) ? INIT_CYC : CONV_LONG;
    localparam int MAX_LEN = (MAX_A > (1 << DUR_W)) ? MAX_A : (1 << DUR_W);
    localparam int CNT_W   = $clog2(MAX_LEN + 1);
    localparam logic [CNT_W-1:0] INIT_LAST  = CNT_W'(INIT_CYC - 1);
    localparam logic [CNT_W-1:0] PINIT_LEN  = CNT_W'(PGA_INIT_CYC);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(CONV_LONG - 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(CONV_SHORT - 1);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, last_q, last_d;
    logic [DUR_W-1:0] pga_q, pga_d, samp_q, samp_d;
    logic             res8_q, res8_d, pwr_q, pwr_d;
    logic             done;

    assign done = (cnt_q == last_q);

    // Next-state and phase-length selection.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        last_d  = last_q;
        pga_d   = pga_q;
        samp_d  = samp_q;
        res8_d  = res8_q;
        pwr_d   = pwr_q;
        case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (start_i) begin
                    res8_d = res8_i;
                    pga_d  = pga_dur_i;
                    samp_d = samp_dur_i;
                    if (pwr_q) begin
                        state_d = ST_PGA;
                        last_d  = CNT_W'(pga_dur_i);
                    end else begin
                        state_d = ST_INIT;
                        last_d  = INIT_LAST;
                    end
                end
            end
            ST_INIT: if (done) begin
                state_d = ST_PGA;
                cnt_d   = '0;
                last_d  = CNT_W'(pga_q);
                pwr_d   = 1'b1;
            end
            ST_PGA: if (done) begin
                state_d = ST_ASAMP;
                cnt_d   = '0;
                last_d  = CNT_W'(samp_q);
            end
            ST_ASAMP: if (done) begin
                state_d = ST_CONV;
                cnt_d   = '0;
                last_d  = res8_q ? SHORT_LAST : LONG_LAST;
            end
            ST_CONV: if (done) begin
                state_d = ST_POST;
                cnt_d   = '0;
            end
            ST_POST: begin
                cnt_d = '0;
                pwr_d = lowlat_i;
                if (freerun_i) begin
                    res8_d = res8_i;
                    pga_d  = pga_dur_i;
                    samp_d = samp_dur_i;
                    if (lowlat_i) begin
                        state_d = ST_PGA;
                        last_d  = CNT_W'(pga_dur_i);
                    end else begin
                        state_d = ST_INIT;
                        last_d  = INIT_LAST;
                    end
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Sequencer registers with synchronous reset.
    always_ff @(posedge clk_adc) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            last_q  <= '0;
            pga_q   <= '0;
            samp_q  <= '0;
            res8_q  <= 1'b0;
            pwr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            last_q  <= last_d;
            pga_q   <= pga_d;
            samp_q  <= samp_d;
            res8_q  <= res8_d;
            pwr_q   <= pwr_d;
        end
    end

    // Phase outputs decoded from registered state.
    always_comb begin
        adc_init_o = (state_q == ST_INIT);
        pga_init_o = (state_q == ST_INIT) && (cnt_q < PINIT_LEN);
        pga_samp_o = ((state_q == ST_INIT) && (cnt_q >= PINIT_LEN))
                   || (state_q == ST_PGA)
                   || ((state_q == ST_IDLE) && pwr_q);
        adc_samp_o = (state_q == ST_ASAMP);
        conv_o     = (state_q == ST_CONV);
        post_o     = (state_q == ST_POST);
        adc_pwr_o  = pwr_q || (state_q != ST_IDLE);
        res8_o     = res8_q;
    end

    // Independent run-length counter for the conversion-phase check.
    logic [CNT_W-1:0] conv_run_q;
    always_ff @(posedge clk_adc) begin
        if (!rst_n) conv_run_q <= '0;
        else        conv_run_q <= conv_o ? conv_run_q + 1'b1 : '0;
    end

    assert_conv_len_R1: assert property (@(posedge clk_adc) disable iff (!rst_n)
        $fell(conv_o) |-> (conv_run_q == (res8_q ? CNT_W'(CONV_SHORT) : CNT_W'(CONV_LONG))));

    assert_phase_onehot_R2: assert property (@(posedge clk_adc) disable iff (!rst_n)
        $onehot0({adc_init_o, adc_samp_o, conv_o, post_o}));

    assert_skip_init_R4: assert property (@(posedge clk_adc) disable iff (!rst_n)
        (state_q == ST_IDLE && pwr_q && start_i) |=> !adc_init_o && !pga_init_o);

    assert_busy_ignore_R10: assert property (@(posedge clk_adc) disable iff (!rst_n)
        (adc_samp_o && !done) |=> adc_samp_o);
endmodule

// File: rtl/adc_seq_post.sv
// Result capture on the falling ADC clock edge during the hand-off phase.
// It formats the word for the selected resolution and toggles a flag so the
// main domain can pick it up.
// Assumes: post_i lasts one ADC cycle, and the hold register stays stable
// until the next hand-off.
module adc_seq_post #(
    parameter int RES_W    = 12,
    parameter int NARROW_W = 8
) (
    input  logic             clk_adc,
    input  logic             rst_n,
    input  logic             post_i,
    input  logic             res8_i,
    input  logic [RES_W-1:0] data_i,
    output logic             tgl_o,
    output logic             mode8_o,
    output logic [RES_W-1:0] hold_o
);
    localparam int PAD_W = RES_W - NARROW_W;

    // Half-cycle capture of the formatted result and toggle of the ready flag.
    always_ff @(negedge clk_adc) begin
        if (!rst_n) begin
            tgl_o   <= 1'b0;
            mode8_o <= 1'b0;
            hold_o  <= '0;
        end else if (post_i) begin
            tgl_o   <= ~tgl_o;
            mode8_o <= res8_i;
            hold_o  <= res8_i ? {{PAD_W{1'b0}}, data_i[NARROW_W-1:0]} : data_i;
        end
    end
endmodule

// File: rtl/adc_seq_xfer.sv
// Main-domain receiver. A two-flop synchronizer and an edge detector turn
// the ADC-side toggle into a one-cycle valid strobe and register the word.
// Assumes: the hold register settles well before the toggle is seen.
module adc_seq_xfer #(
    parameter int RES_W    = 12,
    parameter int NARROW_W = 8
) (
    input  logic             clk_main,
    input  logic             rst_n,
    input  logic             tgl_i,
    input  logic             mode8_i,
    input  logic [RES_W-1:0] hold_i,
    output logic             valid_o,
    output logic [RES_W-1:0] result_o
);
    logic [2:0] sync_q;
    logic       mode8_q;

    // Synchronize the toggle and keep one older copy for edge detection.
    always_ff @(posedge clk_main) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], tgl_i};
    end

    // Register the word and pulse valid on each detected toggle.
    always_ff @(posedge clk_main) begin
        if (!rst_n) begin
            valid_o  <= 1'b0;
            result_o <= '0;
            mode8_q  <= 1'b0;
        end else begin
            valid_o <= sync_q[2] ^ sync_q[1];
            if (sync_q[2] ^ sync_q[1]) begin
                result_o <= hold_i;
                mode8_q  <= mode8_i;
            end
        end
    end

    assert_valid_pulse_R7: assert property (@(posedge clk_main) disable iff (!rst_n)
        valid_o |=> !valid_o);

    assert_narrow_zero_R6: assert property (@(posedge clk_main) disable iff (!rst_n)
        (valid_o && mode8_q) |-> (result_o[RES_W-1:NARROW_W] == '0));
endmodule

// File: rtl/adc_conv_sequencer.sv
// Top level of the conversion timing sequencer: phase control in the ADC
// domain, half-cycle result capture, and result delivery to the main domain.
// Assumes: rst_n is held for several cycles of both clocks.
module adc_conv_sequencer #(
    parameter int INIT_CYC     = 8,
    parameter int PGA_INIT_CYC = 3,
    parameter int DUR_W        = 4,
    parameter int RES_W        = 12,
    parameter int NARROW_W     = 8,
    parameter int CONV_LONG    = 13,
    parameter int CONV_SHORT   = 9
) (
    input  logic             clk_adc,
    input  logic             clk_main,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             res8_i,
    input  logic [DUR_W-1:0] pga_dur_i,
    input  logic [DUR_W-1:0] samp_dur_i,
    input  logic             lowlat_i,
    input  logic             freerun_i,
    input  logic [RES_W-1:0] conv_data_i,
    output logic             adc_pwr_o,
    output logic             adc_init_o,
    output logic             pga_init_o,
    output logic             pga_samp_o,
    output logic             adc_samp_o,
    output logic             conv_o,
    output logic             result_valid_o,
    output logic [RES_W-1:0] result_o
);
    logic             post_w, res8_w, tgl_w, mode8_w;
    logic [RES_W-1:0] hold_w;

    adc_seq_fsm #(
        .INIT_CYC(INIT_CYC), .PGA_INIT_CYC(PGA_INIT_CYC), .DUR_W(DUR_W),
        .CONV_LONG(CONV_LONG), .CONV_SHORT(CONV_SHORT)
    ) u_fsm (
        .clk_adc(clk_adc), .rst_n(rst_n), .start_i(start_i), .res8_i(res8_i),
        .pga_dur_i(pga_dur_i), .samp_dur_i(samp_dur_i), .lowlat_i(lowlat_i),
        .freerun_i(freerun_i), .adc_pwr_o(adc_pwr_o), .adc_init_o(adc_init_o),
        .pga_init_o(pga_init_o), .pga_samp_o(pga_samp_o), .adc_samp_o(adc_samp_o),
        .conv_o(conv_o), .post_o(post_w), .res8_o(res8_w)
    );

    adc_seq_post #(.RES_W(RES_W), .NARROW_W(NARROW_W)) u_post (
        .clk_adc(clk_adc), .rst_n(rst_n), .post_i(post_w), .res8_i(res8_w),
        .data_i(conv_data_i), .tgl_o(tgl_w), .mode8_o(mode8_w), .hold_o(hold_w)
    );

    adc_seq_xfer #(.RES_W(RES_W), .NARROW_W(NARROW_W)) u_xfer (
        .clk_main(clk_main), .rst_n(rst_n), .tgl_i(tgl_w), .mode8_i(mode8_w),
        .hold_i(hold_w), .valid_o(result_valid_o), .result_o(result_o)
    );
endmodule

// File: tb/adc_conv_sequencer_test.sv
module adc_conv_sequencer_test;
    localparam int INIT_CYC = 8;
    localparam int PINIT    = 3;

    logic        clk_main = 0, clk_adc = 0, rst_n = 0;
    logic        start_i = 0, res8_i = 0, lowlat_i = 0, freerun_i = 0;
    logic [3:0]  pga_dur_i = 0, samp_dur_i = 0;
    logic [11:0] conv_data_i = 0;
    logic        adc_pwr_o, adc_init_o, pga_init_o, pga_samp_o, adc_samp_o, conv_o;
    logic        result_valid_o;
    logic [11:0] result_o;

    int checks = 0, fails = 0;
    int cyc = 0, fall_cyc = 0, period = 0;
    int r_init = 0, r_pinit = 0, r_pga = 0, r_asamp = 0, r_conv = 0;
    int w_init = 0, w_pinit = 0, w_pga = 0, w_asamp = 0, w_conv = 0;
    int vcount = 0, wide = 0, lat = 0;
    logic [11:0] last_res = 0;
    logic prev_v = 0;
    bit powered_exp = 0;

    always #5  clk_main = ~clk_main;
    always #10 clk_adc  = ~clk_adc;

    adc_conv_sequencer uut (
        .clk_adc(clk_adc), .clk_main(clk_main), .rst_n(rst_n), .start_i(start_i),
        .res8_i(res8_i), .pga_dur_i(pga_dur_i), .samp_dur_i(samp_dur_i),
        .lowlat_i(lowlat_i), .freerun_i(freerun_i), .conv_data_i(conv_data_i),
        .adc_pwr_o(adc_pwr_o), .adc_init_o(adc_init_o), .pga_init_o(pga_init_o),
        .pga_samp_o(pga_samp_o), .adc_samp_o(adc_samp_o), .conv_o(conv_o),
        .result_valid_o(result_valid_o), .result_o(result_o)
    );

    // Phase run-length monitor, sampled away from both ADC edges.
    always @(negedge clk_adc) begin
        #2;
        cyc++;
        if (adc_init_o) r_init++;  else if (r_init > 0)  begin w_init = r_init;   r_init = 0;  end
        if (pga_init_o) r_pinit++; else if (r_pinit > 0) begin w_pinit = r_pinit; r_pinit = 0; end
        if (pga_samp_o) r_pga++;   else if (r_pga > 0)   begin w_pga = r_pga;     r_pga = 0;   end
        if (adc_samp_o) r_asamp++; else if (r_asamp > 0) begin w_asamp = r_asamp; r_asamp = 0; end
        if (conv_o) r_conv++;
        else if (r_conv > 0) begin
            w_conv = r_conv; r_conv = 0; period = cyc - fall_cyc; fall_cyc = cyc;
        end
    end

    // Result monitor in the main domain.
    always @(negedge clk_main) begin
        #1;
        if (result_valid_o) begin
            if (prev_v) wide++;
            vcount++;
            last_res = result_o;
            lat = cyc - fall_cyc;
        end
        prev_v = result_valid_o;
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_results(int target);
        for (int i = 0; i < 5000 && vcount < target; i++) @(negedge clk_adc);
    endtask

    function automatic logic [11:0] fmt(bit r8, logic [11:0] d);
        return r8 ? {4'h0, d[7:0]} : d;
    endfunction

    task automatic run_conv(bit r8, int pga, int samp, logic [11:0] data, bit ll, bit extra);
        int old;
        @(negedge clk_adc);
        res8_i = r8; pga_dur_i = 4'(pga); samp_dur_i = 4'(samp);
        conv_data_i = data; lowlat_i = ll;
        w_init = 0; w_pinit = 0; w_pga = 0; w_asamp = 0; w_conv = 0;
        old = vcount; wide = 0;
        start_i = 1; @(negedge clk_adc); start_i = 0;
        if (extra) begin
            repeat (5) @(negedge clk_adc);
            start_i = 1; @(negedge clk_adc); start_i = 0;
        end
        wait_results(old + 1);
        repeat (4) @(negedge clk_adc);
        chk("R1 conv length", w_conv, r8 ? 9 : 13);
        chk("R2 sample length", w_asamp, samp + 1);
        if (!powered_exp) begin
            chk("R3 init length", w_init, INIT_CYC);
            chk("R3 pga init length", w_pinit, PINIT);
            chk("R3 stretched pga sampling", w_pga, INIT_CYC - PINIT + pga + 1);
        end else begin
            chk("R4 init skipped", w_init, 0);
            chk("R4 pga init skipped", w_pinit, 0);
        end
        chk("R6 result", int'(last_res), int'(fmt(r8, data)));
        chk("R7 single pulse", wide, 0);
        checks++;
        if (lat < 1 || lat > 4) begin
            fails++;
            $display("FAIL R7 latency: actual %0d expected 1..4", lat);
        end
        chk("R5 idle pga tracking", int'(pga_samp_o), int'(ll));
        chk("R5 idle power", int'(adc_pwr_o), int'(ll));
        if (extra) begin
            repeat (60) @(negedge clk_adc);
            chk("R10 extra trigger ignored", vcount, old + 1);
        end else begin
            chk("R7 one result per conversion", vcount, old + 1);
        end
        powered_exp = ll;
    endtask

    initial begin
        repeat (150000) @(posedge clk_main);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int old;
        void'($urandom(32'd4242));
        repeat (6) @(negedge clk_adc);
        rst_n = 1;
        @(negedge clk_adc); #3;
        chk("R5 reset power", int'(adc_pwr_o), 0);
        chk("R5 reset pga tracking", int'(pga_samp_o), 0);
        chk("R7 reset valid", int'(result_valid_o), 0);
        chk("R6 reset result", int'(result_o), 0);
        chk("R1 reset conv", int'(conv_o), 0);

        run_conv(0, 0, 0, 12'hABC, 0, 0);
        run_conv(1, 15, 15, 12'hFA5, 1, 0);
        run_conv(0, 2, 7, 12'h123, 0, 0);
        run_conv(1, 4, 1, 12'h9E7, 0, 1);
        run_conv(0, 1, 2, 12'h5A5, 1, 1);

        // R8/R9: free-running with low latency, then stop mid-flight.
        @(negedge clk_adc);
        res8_i = 0; pga_dur_i = 2; samp_dur_i = 3; lowlat_i = 1;
        conv_data_i = 12'h777; freerun_i = 1; old = vcount;
        start_i = 1; @(negedge clk_adc); start_i = 0;
        wait_results(old + 3);
        @(negedge clk_adc);
        chk("R8 free-run period", period, 2 + 3 + 13 + 3);
        chk("R6 free-run result", int'(last_res), 12'h777);
        freerun_i = 0;
        repeat (200) @(negedge clk_adc);
        chk("R9 finish then stop", vcount, old + 4);
        chk("R9 idle after stop", int'(conv_o), 0);
        powered_exp = 1;

        for (int k = 0; k < 20; k++) begin
            run_conv(1'($urandom), int'($urandom % 16), int'($urandom % 16),
                     12'($urandom), 1'($urandom), ($urandom % 4) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule